// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of page translations. Every entry holds a virtual page number, the address-space identifier of the process that owns it, a physical frame number and two permission bits. A lookup compares the requested page number and the current address-space identifier against all entries at once. It returns hit, frame and permission bits combinationally, in the same cycle. Because the identifier is part of the tag, translations of several processes can stay resident together without being flushed on a context switch.

On a miss the block only reports the miss. The requester walks the page table elsewhere and then writes the translation back through the fill port. A fill whose key is already resident overwrites that entry. Otherwise the fill takes the lowest-numbered empty entry. When no entry is empty, a round-robin pointer picks the victim. A flush port clears every entry, or only the entries of one address space, in a single cycle.

Top module: `asid_tlb`

## Requirements
- R1: After reset no entry is valid, so every lookup misses until a fill has been written. The round-robin victim pointer starts at entry 0.
- R2: A lookup hits only when a valid entry has a page number equal to `lk_vpn_i` and an identifier equal to `lk_asid_i`. On a hit, `lk_pfn_o`, `lk_wr_o` and `lk_xo_o` carry that entry's stored values. On a miss all three are 0.
- R3: A lookup is answered in the same cycle from the entry state of that cycle. A fill becomes visible to lookups from the next cycle on, and a lookup of the same key in the fill cycle still misses.
- R4: A fill with a key that is not resident goes to the lowest-numbered invalid entry and evicts nothing, so an empty cache of N entries holds N distinct fills.
- R5: When all entries are valid, a fill with a new key replaces the entry at the round-robin pointer. The pointer then advances by one and wraps from N-1 to 0. Successive evictions therefore remove entries in index order.
- R6: A fill whose page number and identifier match a valid entry rewrites that entry's frame and permission bits. It creates no second copy and does not move the round-robin pointer.
- R7: `flush_all_i` invalidates every entry, effective from the next cycle.
- R8: `flush_asid_en_i` invalidates exactly the entries whose identifier equals `flush_asid_i`. Entries of other identifiers keep hitting.
- R9: A fill and a flush in the same cycle both apply, and the flush does not remove the newly filled entry.
- R10: The same page number can be resident under two identifiers at once. Each lookup returns the frame of its own identifier and misses under any identifier that has no translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_vpn_i | input | VPN_W | Page number to translate |
| lk_asid_i | input | ASID_W | Identifier of the current process |
| lk_hit_o | output | 1 | Lookup found a matching valid entry |
| lk_pfn_o | output | PFN_W | Frame number of the matching entry, 0 on miss |
| lk_wr_o | output | 1 | Matching page is writable, 0 on miss |
| lk_xo_o | output | 1 | Matching page is execute-only, 0 on miss |
| fill_en_i | input | 1 | Write a translation this cycle |
| fill_vpn_i | input | VPN_W | Page number of the fill |
| fill_asid_i | input | ASID_W | Identifier of the fill |
| fill_pfn_i | input | PFN_W | Frame number of the fill |
| fill_wr_i | input | 1 | Writable bit of the fill |
| fill_xo_i | input | 1 | Execute-only bit of the fill |
| flush_all_i | input | 1 | Invalidate all entries |
| flush_asid_en_i | input | 1 | Invalidate entries of one identifier |
| flush_asid_i | input | ASID_W | Identifier to invalidate |

## Verification
Lookup results are due in the same cycle as their inputs. The bench drives a lookup just after the falling edge and its monitor samples the outputs 3 ns later, before the next rising edge. The effect of a fill or a flush is due one cycle after the rising edge that captures it. The bench therefore always checks such an effect with a lookup driven on the following falling edge. The one exception is the check that a fill is not yet visible, which puts the lookup in the same cycle as the fill on purpose. Eviction order is observed at the ports by which keys stop hitting after each evicting fill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned DEF_ENTRIES = 32;
  localparam int unsigned DEF_ASID_W  = 8;
  localparam int unsigned DEF_VPN_W   = 22;
  localparam int unsigned DEF_PFN_W   = 22;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_MATCH = 2'd1,
    SRC_FREE  = 2'd2,
    SRC_EVICT = 2'd3
  } fill_src_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int unsigned N_ENTRIES = 32,
  parameter int unsigned ASID_W    = 8,
  parameter int unsigned VPN_W     = 22
) (
  input  logic [N_ENTRIES-1:0]             valid_i,
  input  logic [N_ENTRIES-1:0][ASID_W-1:0] asid_i,
  input  logic [N_ENTRIES-1:0][VPN_W-1:0]  vpn_i,
  input  logic [ASID_W-1:0]                key_asid_i,
  input  logic [VPN_W-1:0]                 key_vpn_i,
  output logic [N_ENTRIES-1:0]             match_o
);
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (vpn_i[g] == key_vpn_i) && (asid_i[g] == key_asid_i);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
  import tlb_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 32,
  localparam int unsigned IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fill_en_i,
  input  logic [N_ENTRIES-1:0] valid_i,
  input  logic [N_ENTRIES-1:0] fill_match_i,
  output logic [N_ENTRIES-1:0] sel_oh_o
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             free_found;
  fill_src_e        src;

  // lowest-numbered invalid entry
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    sel_oh_o = '0;
    src      = SRC_NONE;
    if (fill_en_i) begin
      if (|fill_match_i) begin
        src      = SRC_MATCH;
        sel_oh_o = fill_match_i;
      end else if (free_found) begin
        src              = SRC_FREE;
        sel_oh_o[free_idx] = 1'b1;
      end else begin
        src          = SRC_EVICT;
        sel_oh_o[rr_q] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
    end else if (src == SRC_EVICT) begin
      rr_q <= (rr_q == IDX_W'(N_ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_entries.sv
module tlb_entries #(
  parameter int unsigned N_ENTRIES = 32,
  parameter int unsigned ASID_W    = 8,
  parameter int unsigned VPN_W     = 22,
  parameter int unsigned PFN_W     = 22
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [N_ENTRIES-1:0]             we_oh_i,
  input  logic [ASID_W-1:0]                wr_asid_i,
  input  logic [VPN_W-1:0]                 wr_vpn_i,
  input  logic [PFN_W-1:0]                 wr_pfn_i,
  input  logic                             wr_w_i,
  input  logic                             wr_x_i,
  input  logic                             flush_all_i,
  input  logic                             flush_asid_en_i,
  input  logic [ASID_W-1:0]                flush_asid_i,
  output logic [N_ENTRIES-1:0]             valid_o,
  output logic [N_ENTRIES-1:0][ASID_W-1:0] asid_o,
  output logic [N_ENTRIES-1:0][VPN_W-1:0]  vpn_o,
  output logic [N_ENTRIES-1:0][PFN_W-1:0]  pfn_o,
  output logic [N_ENTRIES-1:0]             w_o,
  output logic [N_ENTRIES-1:0]             x_o
);
  logic [N_ENTRIES-1:0] kill;

  always_comb begin
    for (int i = 0; i < N_ENTRIES; i++) begin
      kill[i] = flush_all_i || (flush_asid_en_i && (asid_o[i] == flush_asid_i));
    end
  end

  // a write in the flush cycle survives the flush
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= '0;
      asid_o  <= '0;
      vpn_o   <= '0;
      pfn_o   <= '0;
      w_o     <= '0;
      x_o     <= '0;
    end else begin
      for (int i = 0; i < N_ENTRIES; i++) begin
        if (we_oh_i[i]) begin
          valid_o[i] <= 1'b1;
          asid_o[i]  <= wr_asid_i;
          vpn_o[i]   <= wr_vpn_i;
          pfn_o[i]   <= wr_pfn_i;
          w_o[i]     <= wr_w_i;
          x_o[i]     <= wr_x_i;
        end else if (kill[i]) begin
          valid_o[i] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int unsigned N_ENTRIES = DEF_ENTRIES,
  parameter int unsigned ASID_W    = DEF_ASID_W,
  parameter int unsigned VPN_W     = DEF_VPN_W,
  parameter int unsigned PFN_W     = DEF_PFN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  output logic              lk_hit_o,
  output logic [PFN_W-1:0]  lk_pfn_o,
  output logic              lk_wr_o,
  output logic              lk_xo_o,
  input  logic              fill_en_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [PFN_W-1:0]  fill_pfn_i,
  input  logic              fill_wr_i,
  input  logic              fill_xo_i,
  input  logic              flush_all_i,
  input  logic              flush_asid_en_i,
  input  logic [ASID_W-1:0] flush_asid_i
);
  logic [N_ENTRIES-1:0]             valid;
  logic [N_ENTRIES-1:0][ASID_W-1:0] asid;
  logic [N_ENTRIES-1:0][VPN_W-1:0]  vpn;
  logic [N_ENTRIES-1:0][PFN_W-1:0]  pfn;
  logic [N_ENTRIES-1:0]             perm_w;
  logic [N_ENTRIES-1:0]             perm_x;
  logic [N_ENTRIES-1:0]             lk_match;
  logic [N_ENTRIES-1:0]             fill_match;
  logic [N_ENTRIES-1:0]             we_oh;

  tlb_entries #(
    .N_ENTRIES(N_ENTRIES), .ASID_W(ASID_W), .VPN_W(VPN_W), .PFN_W(PFN_W)
  ) u_entries (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .we_oh_i         (we_oh),
    .wr_asid_i       (fill_asid_i),
    .wr_vpn_i        (fill_vpn_i),
    .wr_pfn_i        (fill_pfn_i),
    .wr_w_i          (fill_wr_i),
    .wr_x_i          (fill_xo_i),
    .flush_all_i     (flush_all_i),
    .flush_asid_en_i (flush_asid_en_i),
    .flush_asid_i    (flush_asid_i),
    .valid_o         (valid),
    .asid_o          (asid),
    .vpn_o           (vpn),
    .pfn_o           (pfn),
    .w_o             (perm_w),
    .x_o             (perm_x)
  );

  tlb_cam #(.N_ENTRIES(N_ENTRIES), .ASID_W(ASID_W), .VPN_W(VPN_W)) u_lk_cam (
    .valid_i    (valid),
    .asid_i     (asid),
    .vpn_i      (vpn),
    .key_asid_i (lk_asid_i),
    .key_vpn_i  (lk_vpn_i),
    .match_o    (lk_match)
  );

  tlb_cam #(.N_ENTRIES(N_ENTRIES), .ASID_W(ASID_W), .VPN_W(VPN_W)) u_fill_cam (
    .valid_i    (valid),
    .asid_i     (asid),
    .vpn_i      (vpn),
    .key_asid_i (fill_asid_i),
    .key_vpn_i  (fill_vpn_i),
    .match_o    (fill_match)
  );

  tlb_victim #(.N_ENTRIES(N_ENTRIES)) u_victim (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fill_en_i    (fill_en_i),
    .valid_i      (valid),
    .fill_match_i (fill_match),
    .sel_oh_o     (we_oh)
  );

  // and-or read mux; match vector is one-hot or empty
  always_comb begin
    lk_pfn_o = '0;
    lk_wr_o  = 1'b0;
    lk_xo_o  = 1'b0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      lk_pfn_o = lk_pfn_o | ({PFN_W{lk_match[i]}} & pfn[i]);
      lk_wr_o  = lk_wr_o  | (lk_match[i] & perm_w[i]);
      lk_xo_o  = lk_xo_o  | (lk_match[i] & perm_x[i]);
    end
  end

  assign lk_hit_o = |lk_match;
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int unsigned N_ENTRIES = 32,
  parameter int unsigned ASID_W    = 8,
  parameter int unsigned VPN_W     = 22,
  parameter int unsigned PFN_W     = 22
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [VPN_W-1:0]     lk_vpn_i,
  input logic [ASID_W-1:0]    lk_asid_i,
  input logic                 lk_hit_o,
  input logic [PFN_W-1:0]     lk_pfn_o,
  input logic                 lk_wr_o,
  input logic                 lk_xo_o,
  input logic                 fill_en_i,
  input logic [VPN_W-1:0]     fill_vpn_i,
  input logic [ASID_W-1:0]    fill_asid_i,
  input logic [PFN_W-1:0]     fill_pfn_i,
  input logic                 fill_wr_i,
  input logic                 fill_xo_i,
  input logic                 flush_all_i,
  input logic                 flush_asid_en_i,
  input logic [ASID_W-1:0]    flush_asid_i,
  input logic [N_ENTRIES-1:0] lk_match
);
  logic seen_fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_fill_q <= 1'b0;
    else if (fill_en_i) seen_fill_q <= 1'b1;
  end

  assert_reset_empty_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_fill_q |-> !lk_hit_o);

  assert_miss_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> (lk_pfn_o == '0 && !lk_wr_o && !lk_xo_o));

  // R3 and R9: a fill is visible next cycle even under a concurrent flush
  assert_fill_visible_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en_i |=> ((lk_vpn_i != $past(fill_vpn_i)) || (lk_asid_i != $past(fill_asid_i)) ||
                   (lk_hit_o && lk_pfn_o == $past(fill_pfn_i) &&
                    lk_wr_o == $past(fill_wr_i) && lk_xo_o == $past(fill_xo_i))));

  assert_single_copy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match));

  assert_flush_all_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_all_i && !fill_en_i) |=> !lk_hit_o);

  assert_flush_asid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_asid_en_i && !fill_en_i) |=> !(lk_hit_o && lk_asid_i == $past(flush_asid_i)));
endmodule

bind asid_tlb asid_tlb_chk #(
  .N_ENTRIES(N_ENTRIES), .ASID_W(ASID_W), .VPN_W(VPN_W), .PFN_W(PFN_W)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .lk_vpn_i        (lk_vpn_i),
  .lk_asid_i       (lk_asid_i),
  .lk_hit_o        (lk_hit_o),
  .lk_pfn_o        (lk_pfn_o),
  .lk_wr_o         (lk_wr_o),
  .lk_xo_o         (lk_xo_o),
  .fill_en_i       (fill_en_i),
  .fill_vpn_i      (fill_vpn_i),
  .fill_asid_i     (fill_asid_i),
  .fill_pfn_i      (fill_pfn_i),
  .fill_wr_i       (fill_wr_i),
  .fill_xo_i       (fill_xo_i),
  .flush_all_i     (flush_all_i),
  .flush_asid_en_i (flush_asid_en_i),
  .flush_asid_i    (flush_asid_i),
  .lk_match        (lk_match)
);

// File: tb/asid_tlb_test.sv
`timescale 1ns/1ps
module asid_tlb_test;
  localparam int N = 32;
  localparam int AW = 8;
  localparam int VW = 22;
  localparam int PW = 22;

  typedef struct packed {
    logic          hit;
    logic [PW-1:0] pfn;
    logic          wr;
    logic          xo;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [VW-1:0] lk_vpn = '0;
  logic [AW-1:0] lk_asid = '0;
  logic          lk_hit;
  logic [PW-1:0] lk_pfn;
  logic          lk_wr, lk_xo;
  logic          fill_en = 1'b0;
  logic [VW-1:0] fill_vpn = '0;
  logic [AW-1:0] fill_asid = '0;
  logic [PW-1:0] fill_pfn = '0;
  logic          fill_wr = 1'b0, fill_xo = 1'b0;
  logic          fl_all = 1'b0, fl_asid_en = 1'b0;
  logic [AW-1:0] fl_asid = '0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  exp_t  exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  asid_tlb #(.N_ENTRIES(N), .ASID_W(AW), .VPN_W(VW), .PFN_W(PW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_vpn_i(lk_vpn), .lk_asid_i(lk_asid),
    .lk_hit_o(lk_hit), .lk_pfn_o(lk_pfn), .lk_wr_o(lk_wr), .lk_xo_o(lk_xo),
    .fill_en_i(fill_en), .fill_vpn_i(fill_vpn), .fill_asid_i(fill_asid),
    .fill_pfn_i(fill_pfn), .fill_wr_i(fill_wr), .fill_xo_i(fill_xo),
    .flush_all_i(fl_all), .flush_asid_en_i(fl_asid_en), .flush_asid_i(fl_asid)
  );

  task automatic clr();
    fill_en = 1'b0; fl_all = 1'b0; fl_asid_en = 1'b0;
  endtask

  task automatic set_fill(input int v, input int a, input int p, input bit w, input bit x);
    fill_en = 1'b1; fill_vpn = VW'(v); fill_asid = AW'(a);
    fill_pfn = PW'(p); fill_wr = w; fill_xo = x;
  endtask

  task automatic push(input int v, input int a, input bit h, input int p,
                      input bit w, input bit x, input string tag);
    exp_t e;
    lk_vpn = VW'(v); lk_asid = AW'(a);
    e.hit = h; e.pfn = h ? PW'(p) : '0; e.wr = h & w; e.xo = h & x;
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  // driver: one lookup per cycle, expected result queued
  task automatic look(input int v, input int a, input bit h, input int p,
                      input bit w, input bit x, input string tag);
    @(negedge clk); clr();
    push(v, a, h, p, w, x, tag);
  endtask

  task automatic fill(input int v, input int a, input int p, input bit w, input bit x);
    @(negedge clk); clr(); set_fill(v, a, p, w, x);
  endtask

  task automatic idle();
    @(negedge clk); clr();
  endtask

  // monitor: sample lookup outputs 3 ns after the driving edge
  initial begin
    forever begin
      @(negedge clk); #3;
      if (exp_q.size() > 0) begin
        exp_t e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        total++;
        if (lk_hit !== e.hit || lk_pfn !== e.pfn || lk_wr !== e.wr || lk_xo !== e.xo) begin
          bad++;
          $display("FAIL %s: got hit=%0b pfn=%0h wr=%0b xo=%0b exp hit=%0b pfn=%0h wr=%0b xo=%0b",
                   t, lk_hit, lk_pfn, lk_wr, lk_xo, e.hit, e.pfn, e.wr, e.xo);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (lk_hit !== 1'b0) begin
      bad++; $display("FAIL R1 in reset: got hit=%0b exp 0", lk_hit);
    end
    rst_n = 1'b1;
    look(5, 1, 0, 0, 0, 0, "R1 empty after reset");
    look(32'h100, 1, 0, 0, 0, 0, "R1 empty second key");

    // R3: fill and lookup of same key in one cycle misses, hits next cycle
    @(negedge clk); clr(); set_fill(32'h100, 1, 32'hAAA, 1, 0);
    push(32'h100, 1, 0, 0, 0, 0, "R3 not visible in fill cycle");
    look(32'h100, 1, 1, 32'hAAA, 1, 0, "R3 visible next cycle");
    look(32'h100, 1, 1, 32'hAAA, 1, 0, "R2 hit returns frame and bits");

    // R10: same page, other identifier
    look(32'h100, 2, 0, 0, 0, 0, "R10 other asid misses");
    fill(32'h100, 2, 32'hBBB, 0, 1);
    look(32'h100, 2, 1, 32'hBBB, 0, 1, "R10 asid 2 own frame");
    look(32'h100, 1, 1, 32'hAAA, 1, 0, "R10 asid 1 still own frame");
    look(32'h101, 1, 0, 0, 0, 0, "R2 different vpn misses");

    // R6: overwrite in place
    fill(32'h100, 1, 32'hCCC, 0, 0);
    look(32'h100, 1, 1, 32'hCCC, 0, 0, "R6 rewritten frame");

    // R4: fill remaining 30 entries, nothing evicted
    for (int i = 0; i < N - 2; i++) fill(32'h200 + i, 3, 32'h1000 + i, i[0], 0);
    look(32'h100, 1, 1, 32'hCCC, 0, 0, "R4 first entry kept");
    look(32'h100, 2, 1, 32'hBBB, 0, 1, "R4 second entry kept");
    for (int i = 0; i < N - 2; i++)
      look(32'h200 + i, 3, 1, 32'h1000 + i, i[0], 0, "R4 full cache all resident");

    // R6 on full cache: no eviction, pointer unmoved
    fill(32'h205, 3, 32'h7777, 1, 1);
    look(32'h205, 3, 1, 32'h7777, 1, 1, "R6 overwrite on full cache");
    look(32'h100, 1, 1, 32'hCCC, 0, 0, "R6 no eviction on overwrite");

    // R5: evictions follow index order starting at entry 0
    fill(32'h300, 4, 32'h300, 0, 0);
    look(32'h300, 4, 1, 32'h300, 0, 0, "R5 new key resident");
    look(32'h100, 1, 0, 0, 0, 0, "R5 entry 0 evicted first");
    look(32'h100, 2, 1, 32'hBBB, 0, 1, "R5 entry 1 kept after first eviction");
    fill(32'h301, 4, 32'h301, 1, 0);
    look(32'h100, 2, 0, 0, 0, 0, "R5 entry 1 evicted second");
    look(32'h200, 3, 1, 32'h1000, 0, 0, "R5 entry 2 kept");
    look(32'h301, 4, 1, 32'h301, 1, 0, "R5 second new key resident");

    // R8 with R9: flush asid 3 and fill an asid 3 key in the same cycle
    @(negedge clk); clr(); fl_asid_en = 1'b1; fl_asid = 8'd3;
    set_fill(32'h250, 3, 32'h55, 1, 0);
    look(32'h250, 3, 1, 32'h55, 1, 0, "R9 fill survives asid flush");
    look(32'h200, 3, 0, 0, 0, 0, "R8 asid 3 entry flushed");
    look(32'h205, 3, 0, 0, 0, 0, "R8 asid 3 entry flushed");
    look(32'h21D, 3, 0, 0, 0, 0, "R8 last asid 3 entry flushed");
    look(32'h300, 4, 1, 32'h300, 0, 0, "R8 asid 4 untouched");
    look(32'h301, 4, 1, 32'h301, 1, 0, "R8 asid 4 untouched");

    // R4: freed entries reused without eviction
    fill(32'h400, 5, 32'h44, 0, 1);
    look(32'h400, 5, 1, 32'h44, 0, 1, "R4 fill into freed entry");
    look(32'h300, 4, 1, 32'h300, 0, 0, "R4 no eviction with free entries");
    look(32'h250, 3, 1, 32'h55, 1, 0, "R4 no eviction with free entries");

    // R7 with R9: flush all plus fill in the same cycle
    @(negedge clk); clr(); fl_all = 1'b1;
    set_fill(32'h500, 6, 32'h9, 1, 1);
    look(32'h500, 6, 1, 32'h9, 1, 1, "R9 fill survives flush all");
    look(32'h300, 4, 0, 0, 0, 0, "R7 flush all cleared entry");
    look(32'h400, 5, 0, 0, 0, 0, "R7 flush all cleared entry");
    look(32'h250, 3, 0, 0, 0, 0, "R7 flush all cleared entry");

    // R7 plain flush all
    @(negedge clk); clr(); fl_all = 1'b1;
    look(32'h500, 6, 0, 0, 0, 0, "R7 plain flush all");

    idle(); idle(); idle();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule